// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the purely combinational control unit of a single-cycle 32-bit load/store processor. Each cycle it takes the six opcode bits of the fetched instruction (instruction bits 31:26), a flag saying whether the branch-test register holds zero, and an interrupt request. From these it derives every steering signal the datapath needs: the next-PC source, the address source of the second register read port, the ALU operand selects, the ALU function, the write-back data source, and the register-file and memory write enables. It also drives a select that sends the register write to the exception-link register (register 30) instead of the instruction's Rc field.

The decoder handles register-register ALU operations, ALU operations with a sign-extended literal, load, store, register-indirect jump, branch-if-zero, branch-if-nonzero and PC-relative load. An opcode it does not recognise, and any interrupt request, turn into a forced call. The PC moves to a trap vector and PC+4 is saved in register 30. An interrupt request takes precedence over the instruction in flight, which is then not executed.

Top module: `ctl_decoder`

## Requirements
- R1: For opcodes 10xxxx that are supported, the outputs are pc_sel 0, b_sel 0, wd_sel 1, rf_we 1 and mem_we 0. alu_fn follows from the low four opcode bits: 0→0 (ADD), 1→1 (SUB), 4→2 (CMPEQ), 5→3 (CMPLT), 6→4 (CMPLE), 8→5 (AND), 9→6 (OR), 10→7 (XOR), 12→8 (SHL), 13→9 (SHR), 14→10 (SRA).
- R2: Opcodes 11xxxx that are supported behave as in R1, with the same alu_fn mapping, except that b_sel is 1 (literal operand).
- R3: In both ALU classes the low nibbles 2, 3, 7, 11 and 15 are not supported (this includes multiply and divide). They are handled as illegal opcodes, as in R9.
- R4: LD (011000) gives b_sel 1, alu_fn 0 (ADD), wd_sel 2 (memory data), rf_we 1, mem_we 0 and pc_sel 0.
- R5: ST (011001) gives b_sel 1, alu_fn 0, ra2_sel 1 (Rc on read port 2), mem_we 1, rf_we 0 and pc_sel 0.
- R6: JMP (011011) gives pc_sel 2, wd_sel 0 (PC+4), rf_we 1 and mem_we 0.
- R7: BEQ (011101) gives pc_sel 1 when zero is 1 and pc_sel 0 when zero is 0. BNE (011110) does the reverse. Both give wd_sel 0, rf_we 1 and mem_we 0.
- R8: LDR (011111) gives a_sel 1 (branch-target address as operand A), alu_fn 11 (pass A), wd_sel 2, rf_we 1, mem_we 0 and pc_sel 0.
- R9: Any other opcode, with irq low, gives pc_sel 3, wa_sel 1 (register 30), wd_sel 0, rf_we 1 and mem_we 0.
- R10: irq high gives pc_sel 4, wa_sel 1, wd_sel 0, rf_we 1 and mem_we 0, whatever the opcode and the zero flag are.
- R11: Any output that R1 to R10 do not set for a case is 0. In particular wa_sel is 1 only in trap cases, ra2_sel only for ST and a_sel only for LDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction bits 31:26 |
| zero | input | 1 | Branch-test register equals zero |
| irq | input | 1 | Asynchronous interrupt request |
| pc_sel | output | 3 | Next PC: 0 PC+4, 1 branch target, 2 register, 3 illegal vector, 4 interrupt vector |
| ra2_sel | output | 1 | Read port 2 address: 0 Rb, 1 Rc |
| a_sel | output | 1 | ALU A: 0 register, 1 branch-target address |
| b_sel | output | 1 | ALU B: 0 register, 1 sign-extended literal |
| alu_fn | output | 4 | ALU function code |
| wd_sel | output | 2 | Write-back: 0 PC+4, 1 ALU, 2 memory data |
| rf_we | output | 1 | Register file write enable |
| wa_sel | output | 1 | Write address: 0 Rc, 1 register 30 |
| mem_we | output | 1 | Data memory write enable |

## Verification
An interrupt request can arrive in the same cycle as any opcode. That includes a store, which would write memory, and a taken branch, which would redirect the PC. The bench sweeps all 64 opcodes with every combination of zero and irq. Each irq-high vector is judged against the interrupt controls alone, so a store must not write and a branch must not win in that cycle. Illegal opcodes together with irq check that the interrupt vector outranks the illegal-opcode vector.

// File: rtl/ctl_pkg.sv
// Package: shared encodings of the control decoder.
// Assumes a 6-bit opcode field and a 4-bit ALU function code.
package ctl_pkg;
    localparam int OPC_W    = 6;
    localparam int NIB_W    = 4;
    localparam int PCSEL_W  = 3;
    localparam int WDSEL_W  = 2;
    localparam int ALUFN_W  = 4;

    typedef enum logic [PCSEL_W-1:0] {
        PCS_SEQ = 3'd0,
        PCS_BR  = 3'd1,
        PCS_JR  = 3'd2,
        PCS_ILL = 3'd3,
        PCS_IRQ = 3'd4
    } pcsel_t;

    typedef enum logic [WDSEL_W-1:0] {
        WDS_PC4 = 2'd0,
        WDS_ALU = 2'd1,
        WDS_MEM = 2'd2
    } wdsel_t;

    typedef enum logic [ALUFN_W-1:0] {
        FN_ADD   = 4'd0,
        FN_SUB   = 4'd1,
        FN_CMPEQ = 4'd2,
        FN_CMPLT = 4'd3,
        FN_CMPLE = 4'd4,
        FN_AND   = 4'd5,
        FN_OR    = 4'd6,
        FN_XOR   = 4'd7,
        FN_SHL   = 4'd8,
        FN_SHR   = 4'd9,
        FN_SRA   = 4'd10,
        FN_PASSA = 4'd11
    } alufn_t;

    typedef enum logic [3:0] {
        CL_ALU_R,
        CL_ALU_L,
        CL_LD,
        CL_ST,
        CL_JMP,
        CL_BEQ,
        CL_BNE,
        CL_LDR,
        CL_ILL
    } opclass_t;
endpackage

// File: rtl/ctl_alufn.sv
// Module: ctl_alufn
// Maps the low opcode nibble of an ALU-class instruction to the ALU
// function code and reports whether the nibble names a supported operation.
// Assumes multiply, divide and the gaps in the map are unsupported.
module ctl_alufn
    import ctl_pkg::*;
(
    input  logic [NIB_W-1:0] nibble,
    output alufn_t           fn,
    output logic             valid
);
    // Lookup of the function code for each nibble value.
    always_comb begin
        valid = 1'b1;
        fn    = FN_ADD;
        case (nibble)
            4'd0:    fn = FN_ADD;
            4'd1:    fn = FN_SUB;
            4'd4:    fn = FN_CMPEQ;
            4'd5:    fn = FN_CMPLT;
            4'd6:    fn = FN_CMPLE;
            4'd8:    fn = FN_AND;
            4'd9:    fn = FN_OR;
            4'd10:   fn = FN_XOR;
            4'd12:   fn = FN_SHL;
            4'd13:   fn = FN_SHR;
            4'd14:   fn = FN_SRA;
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctl_opclass.sv
// Module: ctl_opclass
// Sorts the opcode into an instruction class. ALU opcodes whose function
// is unsupported, and every unlisted opcode, fall into the illegal class.
// Assumes alu_ok comes from ctl_alufn for the same opcode.
module ctl_opclass
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_ok,
    output opclass_t         op_class
);
    localparam logic [OPC_W-1:0] OP_LD  = 6'b011000;
    localparam logic [OPC_W-1:0] OP_ST  = 6'b011001;
    localparam logic [OPC_W-1:0] OP_JMP = 6'b011011;
    localparam logic [OPC_W-1:0] OP_BEQ = 6'b011101;
    localparam logic [OPC_W-1:0] OP_BNE = 6'b011110;
    localparam logic [OPC_W-1:0] OP_LDR = 6'b011111;

    // Class selection from the two top bits, then the exact codes.
    always_comb begin
        op_class = CL_ILL;
        case (opcode[OPC_W-1 -: 2])
            2'b10: op_class = alu_ok ? CL_ALU_R : CL_ILL;
            2'b11: op_class = alu_ok ? CL_ALU_L : CL_ILL;
            2'b01: begin
                case (opcode)
                    OP_LD:   op_class = CL_LD;
                    OP_ST:   op_class = CL_ST;
                    OP_JMP:  op_class = CL_JMP;
                    OP_BEQ:  op_class = CL_BEQ;
                    OP_BNE:  op_class = CL_BNE;
                    OP_LDR:  op_class = CL_LDR;
                    default: op_class = CL_ILL;
                endcase
            end
            default: op_class = CL_ILL;
        endcase
    end
endmodule

// File: rtl/ctl_pcsel.sv
// Module: ctl_pcsel
// Chooses the next-PC source from the class, the zero flag and the
// interrupt request. An interrupt outranks every class.
module ctl_pcsel
    import ctl_pkg::*;
(
    input  opclass_t op_class,
    input  logic     zero,
    input  logic     irq,
    output pcsel_t   pc_sel
);
    // Priority: interrupt, then class-specific source.
    always_comb begin
        pc_sel = PCS_SEQ;
        if (irq) begin
            pc_sel = PCS_IRQ;
        end else begin
            case (op_class)
                CL_JMP:  pc_sel = PCS_JR;
                CL_BEQ:  pc_sel = zero ? PCS_BR : PCS_SEQ;
                CL_BNE:  pc_sel = zero ? PCS_SEQ : PCS_BR;
                CL_ILL:  pc_sel = PCS_ILL;
                default: pc_sel = PCS_SEQ;
            endcase
        end
    end
endmodule

// File: rtl/ctl_decoder.sv
// Module: ctl_decoder (top)
// Combinational control unit of a single-cycle processor. It produces all
// datapath selects and write enables for one instruction. Traps save PC+4
// into register 30 via wa_sel. Holds no state, so it has no clock or reset.
module ctl_decoder
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    input  logic               zero,
    input  logic               irq,
    output logic [PCSEL_W-1:0] pc_sel,
    output logic               ra2_sel,
    output logic               a_sel,
    output logic               b_sel,
    output logic [ALUFN_W-1:0] alu_fn,
    output logic [WDSEL_W-1:0] wd_sel,
    output logic               rf_we,
    output logic               wa_sel,
    output logic               mem_we
);
    alufn_t   nib_fn;
    logic     nib_ok;
    opclass_t op_class;
    pcsel_t   pc_next;
    alufn_t   fn_q;
    wdsel_t   wd_q;

    ctl_alufn u_alufn (
        .nibble (opcode[NIB_W-1:0]),
        .fn     (nib_fn),
        .valid  (nib_ok)
    );

    ctl_opclass u_opclass (
        .opcode   (opcode),
        .alu_ok   (nib_ok),
        .op_class (op_class)
    );

    ctl_pcsel u_pcsel (
        .op_class (op_class),
        .zero     (zero),
        .irq      (irq),
        .pc_sel   (pc_next)
    );

    // Per-class datapath steering; traps override everything else.
    always_comb begin
        ra2_sel = 1'b0;
        a_sel   = 1'b0;
        b_sel   = 1'b0;
        fn_q    = FN_ADD;
        wd_q    = WDS_PC4;
        rf_we   = 1'b0;
        wa_sel  = 1'b0;
        mem_we  = 1'b0;
        if (irq || op_class == CL_ILL) begin
            rf_we  = 1'b1;
            wa_sel = 1'b1;
        end else begin
            case (op_class)
                CL_ALU_R: begin fn_q = nib_fn; wd_q = WDS_ALU; rf_we = 1'b1; end
                CL_ALU_L: begin fn_q = nib_fn; wd_q = WDS_ALU; rf_we = 1'b1; b_sel = 1'b1; end
                CL_LD:    begin b_sel = 1'b1; wd_q = WDS_MEM; rf_we = 1'b1; end
                CL_ST:    begin b_sel = 1'b1; ra2_sel = 1'b1; mem_we = 1'b1; end
                CL_JMP, CL_BEQ, CL_BNE: rf_we = 1'b1;
                CL_LDR:   begin a_sel = 1'b1; fn_q = FN_PASSA; wd_q = WDS_MEM; rf_we = 1'b1; end
                default:  rf_we = 1'b0;
            endcase
        end
    end

    // Output packing to plain vectors.
    always_comb begin
        pc_sel = pc_next;
        alu_fn = fn_q;
        wd_sel = wd_q;
    end

    // Cross-checks between the next-PC unit and the steering logic.
    always_comb begin
        if (pc_next == PCS_ILL || pc_next == PCS_IRQ) begin
            AST_TRAP_SAVES_LINK: assert (wa_sel && rf_we && wd_q == WDS_PC4 && !mem_we)
                else $error("trap without link save"); // R9
        end
        if (irq) begin
            AST_IRQ_FIRST: assert (pc_next == PCS_IRQ && !mem_we)
                else $error("interrupt not first"); // R10
        end
        if (wa_sel) begin
            AST_LINK_ONLY_TRAP: assert (pc_next == PCS_ILL || pc_next == PCS_IRQ)
                else $error("link write outside trap"); // R11
        end
        if (mem_we) begin
            AST_STORE_NO_RF: assert (!rf_we && ra2_sel && pc_next == PCS_SEQ)
                else $error("store with register write"); // R5
        end
        if (!irq && opcode == 6'b011101) begin
            AST_BEQ_ZERO: assert (pc_next == (zero ? PCS_BR : PCS_SEQ))
                else $error("beq target wrong"); // R7
        end
    end
endmodule

// File: tb/ctl_decoder_tb.sv
module ctl_decoder_tb;
    logic       clk = 1'b0;
    logic [5:0] opcode;
    logic       zero, irq;
    logic [2:0] pc_sel;
    logic       ra2_sel, a_sel, b_sel, rf_we, wa_sel, mem_we;
    logic [3:0] alu_fn;
    logic [1:0] wd_sel;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ctl_decoder u_dut (
        .opcode (opcode), .zero (zero), .irq (irq),
        .pc_sel (pc_sel), .ra2_sel (ra2_sel), .a_sel (a_sel), .b_sel (b_sel),
        .alu_fn (alu_fn), .wd_sel (wd_sel), .rf_we (rf_we), .wa_sel (wa_sel),
        .mem_we (mem_we)
    );

    // Expected ALU code for a nibble; -1 means unsupported (R1, R3).
    function automatic int fn_of(input int nib);
        case (nib)
            0: return 0;   1: return 1;   4: return 2;   5: return 3;
            6: return 4;   8: return 5;   9: return 6;  10: return 7;
            12: return 8; 13: return 9;  14: return 10;
            default: return -1;
        endcase
    endfunction

    // Drive every opcode with every zero/irq pair; judge the packed vector.
    initial begin
        opcode = '0; zero = 1'b0; irq = 1'b0;
        for (int op = 0; op < 64; op++) begin
            for (int z = 0; z < 2; z++) begin
                for (int q = 0; q < 2; q++) begin
                    int e_pc, e_fn, e_wd;
                    bit e_ra2, e_a, e_b, e_rf, e_wa, e_mem;
                    string tag;
                    logic [15:0] exp_v, act_v;
                    @(posedge clk); #1;
                    opcode = 6'(op); zero = z[0]; irq = q[0];
                    e_pc = 0; e_fn = 0; e_wd = 0;
                    e_ra2 = 0; e_a = 0; e_b = 0; e_rf = 0; e_wa = 0; e_mem = 0;
                    if (q == 1) begin
                        tag = "R10"; e_pc = 4; e_wa = 1; e_rf = 1;
                    end else if ((op >> 4) >= 2 && fn_of(op % 16) >= 0) begin
                        tag = ((op >> 4) == 2) ? "R1,R11" : "R2,R11";
                        e_fn = fn_of(op % 16); e_wd = 1; e_rf = 1;
                        e_b = ((op >> 4) == 3);
                    end else if (op == 24) begin
                        tag = "R4"; e_b = 1; e_wd = 2; e_rf = 1;
                    end else if (op == 25) begin
                        tag = "R5"; e_b = 1; e_ra2 = 1; e_mem = 1;
                    end else if (op == 27) begin
                        tag = "R6"; e_pc = 2; e_rf = 1;
                    end else if (op == 29 || op == 30) begin
                        tag = "R7"; e_rf = 1;
                        e_pc = ((op == 29) == (z == 1)) ? 1 : 0;
                    end else if (op == 31) begin
                        tag = "R8"; e_a = 1; e_fn = 11; e_wd = 2; e_rf = 1;
                    end else begin
                        tag = ((op >> 4) >= 2) ? "R3,R9" : "R9,R11";
                        e_pc = 3; e_wa = 1; e_rf = 1;
                    end
                    exp_v = {3'(e_pc), e_ra2, e_a, e_b, 4'(e_fn), 2'(e_wd), e_rf, e_wa, e_mem};
                    @(negedge clk);
                    act_v = {pc_sel, ra2_sel, a_sel, b_sel, alu_fn, wd_sel, rf_we, wa_sel, mem_we};
                    checks++;
                    if (act_v !== exp_v) begin
                        errors++;
                        $display("FAIL %s op=%06b zero=%0d irq=%0d actual=%04h expected=%04h",
                                 tag, op[5:0], z, q, act_v, exp_v);
                    end
                end
            end
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule